// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Subframe Transmitter

This block turns a stream of 16-bit stereo PCM pairs into a single-wire consumer digital audio line signal. A line cell is produced each time the cell-rate enable is high. A stereo frame is 128 cells, made of a left and a right subframe of 64 cells each. Every subframe opens with an 8-cell synchronisation pattern that breaks the coding rule on purpose. It then carries 28 coded bit slots of two cells each: auxiliary and unused low audio slots, the sample with its least significant bit first, and then the validity, user, status and parity slots.

Samples enter through a valid/ready handshake, one stereo pair per transfer. A single holding register takes the pair. The pair moves into the transmit register only at the first cell of a frame, so both halves of a frame always come from the same pair. If no pair is waiting when a frame begins, the frame still goes out with all audio slots zero. A mute input marks the audio as not valid and leaves the timing unchanged.

Top module: `spdif_tx`

## Requirements
- R1: `line_out` changes only on a clock edge where `cell_en` is high; each such edge emits exactly one cell, 64 cells make a subframe (left first, then right) and 128 make a frame.
- R2: Cells 0..7 of a subframe, first cell first, are 11101000 for a left subframe that starts a block, 11100010 for any other left subframe and 11100100 for every right subframe.
- R3: Left subframes use the block-start pattern once every 192 frames; the first frame after reset is a block-start frame.
- R4: Bit slot k occupies subframe cells 2k and 2k+1 (k = 4..31). Slots 4..11 carry 0, slots 12..27 carry sample bits 0..15 (left sample in the left subframe, right sample in the right), and slots 29 and 30 carry 0.
- R5: Biphase-mark coding: the first cell of every slot is the inverse of the preceding cell, and the second cell is inverted again only when the slot's bit is 1.
- R6: A frame that starts with no pair waiting sends zero in every audio slot; when not muted, cells 8..63 of each subframe are the pattern 1,1,0,0 repeated.
- R7: Slot 31 makes slots 4..31 hold an even number of ones, so the line is low in the cell before every synchronisation pattern.
- R8: Slot 28 (validity) is 1 when `mute` was high at the first cell of that subframe and 0 otherwise; mute changes no other slot and no pattern.
- R9: `smp_ready` is high exactly when the holding register is empty. A pair is accepted on an edge with `smp_valid` and `smp_ready` both high, and it is transmitted starting at the next frame boundary; `smp_ready` rises again only at that boundary.
- R10: Reset drives `line_out` low, empties the holding and transmit registers (`smp_ready` high) and clears the frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_en | input | 1 | One-cycle strobe per line cell |
| smp_valid | input | 1 | A stereo pair is offered |
| smp_ready | output | 1 | Holding register is empty |
| smp_left | input | 16 | Left PCM sample |
| smp_right | input | 16 | Right PCM sample |
| mute | input | 1 | Flag the audio as not valid |
| line_out | output | 1 | Serial coded line level |

## Verification
On every cycle, the assertions check several properties. The line stays put between cell strobes and is low before each synchronisation pattern. Every data slot opens with a transition. The handshake only reopens at a frame boundary. The block-start pattern comes 192 frames apart and on the first frame after reset. The exact cell values depend on sample content, mute timing and underrun gaps, so only the bench's scenarios can show them. This covers slot placement, least-significant-bit-first ordering, parity under mute, the three synchronisation patterns and silence frames. The bench checks them against a behavioural model cell by cell.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

  localparam int SMP_W       = 16;
  localparam int SLOT_CNT    = 32;
  localparam int CELLS_SUB   = 2 * SLOT_CNT;
  localparam int CELLS_FRM   = 2 * CELLS_SUB;
  localparam int CELL_W      = $clog2(CELLS_FRM);
  localparam int SUB_W       = $clog2(CELLS_SUB);
  localparam int SLOT_W      = $clog2(SLOT_CNT);
  localparam int SYNC_CELLS  = 8;
  localparam int FIRST_SLOT  = SYNC_CELLS / 2;
  localparam int VAL_SLOT    = SLOT_CNT - 4;
  localparam int AUD_SLOT    = VAL_SLOT - SMP_W;
  localparam int PAR_SLOT    = SLOT_CNT - 1;

  typedef enum logic [1:0] {
    SYNC_BLOCK = 2'd0,
    SYNC_LEFT  = 2'd1,
    SYNC_RIGHT = 2'd2
  } sync_kind_t;

  // Cell pattern of a synchronisation field, first cell in the MSB.
  function automatic logic [SYNC_CELLS-1:0] sync_cells(input sync_kind_t kind);
    case (kind)
      SYNC_BLOCK: return 8'b1110_1000;
      SYNC_LEFT:  return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction

  // Slot contents of one subframe, indexed by slot number.
  function automatic logic [SLOT_CNT-1:0] slot_word(input logic [SMP_W-1:0] smp,
                                                    input logic not_valid);
    logic [SLOT_CNT-1:0] w;
    w = '0;
    w[AUD_SLOT +: SMP_W] = smp;
    w[VAL_SLOT]          = not_valid;
    w[PAR_SLOT]          = ^w[PAR_SLOT-1:FIRST_SLOT];
    return w;
  endfunction

  // Biphase-mark cell from the previous cell level.
  function automatic logic bmc_cell(input logic prev, input logic bit_v,
                                    input logic second);
    return second ? (prev ^ bit_v) : ~prev;
  endfunction

endpackage

// File: rtl/spdif_cell_seq.sv
module spdif_cell_seq
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = (BLOCK_FRAMES > 1) ? $clog2(BLOCK_FRAMES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_en,
  output logic [CELL_W-1:0] cell_idx,
  output logic              frame_start,
  output logic              sub_start,
  output logic              is_right,
  output logic              blk_frame
);

  logic [FW-1:0] frame_idx;
  logic          frame_last;
  logic          cell_last;

  assign cell_last   = (cell_idx == CELL_W'(CELLS_FRM - 1));
  assign frame_last  = (frame_idx == FW'(BLOCK_FRAMES - 1));
  assign frame_start = cell_en && (cell_idx == '0);
  assign sub_start   = cell_en && (cell_idx[SUB_W-1:0] == '0);
  assign is_right    = cell_idx[CELL_W-1];
  assign blk_frame   = (frame_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_idx  <= '0;
      frame_idx <= '0;
    end else if (cell_en) begin
      cell_idx <= cell_idx + 1'b1;
      if (cell_last) begin
        frame_idx <= frame_last ? '0 : frame_idx + 1'b1;
      end
    end
  end

endmodule

// File: rtl/spdif_pair_hold.sv
module spdif_pair_hold
  import spdif_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SMP_W-1:0] in_left,
  input  logic [SMP_W-1:0] in_right,
  input  logic             frame_start,
  output logic [SMP_W-1:0] tx_left,
  output logic [SMP_W-1:0] tx_right,
  output logic             tx_live,
  output logic             pair_take
);

  logic             hold_v;
  logic [SMP_W-1:0] hold_l;
  logic [SMP_W-1:0] hold_r;
  logic             accept;

  assign in_ready  = !hold_v;
  assign accept    = in_valid && in_ready;
  assign pair_take = frame_start && hold_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
    end else if (accept) begin
      hold_v <= 1'b1;
      hold_l <= in_left;
      hold_r <= in_right;
    end else if (pair_take) begin
      hold_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_live  <= 1'b0;
      tx_left  <= '0;
      tx_right <= '0;
    end else if (frame_start) begin
      tx_live  <= hold_v;
      tx_left  <= hold_v ? hold_l : '0;
      tx_right <= hold_v ? hold_r : '0;
    end
  end

endmodule

// File: rtl/spdif_bmc_line.sv
module spdif_bmc_line
  import spdif_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cell_en,
  input  logic [CELL_W-1:0]   cell_idx,
  input  sync_kind_t          sync_kind,
  input  logic [SLOT_CNT-1:0] word,
  output logic                line_q,
  output logic                slot_head
);

  logic [SUB_W-1:0]      pos;
  logic [SLOT_W-1:0]     slot;
  logic [SYNC_CELLS-1:0] pat;
  logic                  in_sync;
  logic                  nxt;

  assign pos       = cell_idx[SUB_W-1:0];
  assign slot      = pos[SUB_W-1:1];
  assign in_sync   = (pos < SUB_W'(SYNC_CELLS));
  assign pat       = sync_cells(sync_kind);
  assign slot_head = cell_en && !in_sync && !pos[0];

  always_comb begin
    if (in_sync) begin
      nxt = pat[3'(SYNC_CELLS - 1) - pos[2:0]];
    end else begin
      nxt = bmc_cell(line_q, word[slot], pos[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else if (cell_en) begin
      line_q <= nxt;
    end
  end

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
  import spdif_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_en,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic             mute,
  output logic             line_out
);

  logic [CELL_W-1:0]   cell_idx;
  logic                frame_start;
  logic                sub_start;
  logic                is_right;
  logic                blk_frame;
  logic [SMP_W-1:0]    tx_left;
  logic [SMP_W-1:0]    tx_right;
  logic                tx_live;
  logic                pair_take;
  logic                mute_sub;
  logic                slot_head;
  sync_kind_t          sync_kind;
  logic [SLOT_CNT-1:0] word;

  spdif_cell_seq #(.BLOCK_FRAMES(BLOCK_FRAMES)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cell_en     (cell_en),
    .cell_idx    (cell_idx),
    .frame_start (frame_start),
    .sub_start   (sub_start),
    .is_right    (is_right),
    .blk_frame   (blk_frame)
  );

  spdif_pair_hold hold_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (smp_valid),
    .in_ready    (smp_ready),
    .in_left     (smp_left),
    .in_right    (smp_right),
    .frame_start (frame_start),
    .tx_left     (tx_left),
    .tx_right    (tx_right),
    .tx_live     (tx_live),
    .pair_take   (pair_take)
  );

  // Validity flag is frozen for a whole subframe so parity stays consistent.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute_sub <= 1'b0;
    end else if (sub_start) begin
      mute_sub <= mute;
    end
  end

  always_comb begin
    if (is_right)       sync_kind = SYNC_RIGHT;
    else if (blk_frame) sync_kind = SYNC_BLOCK;
    else                sync_kind = SYNC_LEFT;
  end

  assign word = slot_word(is_right ? tx_right : tx_left, mute_sub);

  spdif_bmc_line line_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cell_en   (cell_en),
    .cell_idx  (cell_idx),
    .sync_kind (sync_kind),
    .word      (word),
    .line_q    (line_out),
    .slot_head (slot_head)
  );

endmodule

// File: rtl/spdif_tx_chk.sv
module spdif_tx_chk #(
  parameter int BLOCK_FRAMES = 192,
  localparam int SW = $clog2(BLOCK_FRAMES + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic cell_en,
  input logic smp_valid,
  input logic smp_ready,
  input logic line_out,
  input logic frame_start,
  input logic sub_start,
  input logic slot_head,
  input logic blk_frame,
  input logic tx_live
);

  logic [SW-1:0] since_blk;
  logic          blk_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_blk <= '0;
      blk_seen  <= 1'b0;
    end else if (frame_start) begin
      if (blk_frame) begin
        since_blk <= '0;
        blk_seen  <= 1'b1;
      end else begin
        since_blk <= since_blk + 1'b1;
      end
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> $stable(line_out)); // R1

  AST_SYNC_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    sub_start |-> !line_out); // R7

  AST_SLOT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_head |=> (line_out != $past(line_out))); // R5

  AST_BLK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !blk_seen) |-> blk_frame); // R3

  AST_BLK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && blk_seen) |-> (blk_frame == (since_blk == SW'(BLOCK_FRAMES - 1)))); // R3

  AST_READY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> !smp_ready); // R9

  AST_READY_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && !frame_start) |=> !smp_ready); // R9

  AST_TAKE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !smp_ready) |=> tx_live); // R9

endmodule

bind spdif_tx spdif_tx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cell_en     (cell_en),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .line_out    (line_out),
  .frame_start (frame_start),
  .sub_start   (sub_start),
  .slot_head   (slot_head),
  .blk_frame   (blk_frame),
  .tx_live     (tx_live)
);

// File: tb/spdif_tx_tb.sv
`timescale 1ns/1ps
module spdif_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cell_en = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_left = '0;
  logic [15:0] smp_right = '0;
  logic        mute = 1'b0;
  logic        line_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  spdif_tx dut_i (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .mute(mute), .line_out(line_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int   m_cnt = 0, m_frame = 0, m_pos = 0;
  bit   m_level = 0, m_pend = 0, m_live = 0, m_mute = 0, m_new = 0;
  logic [15:0] m_pl, m_pr, m_al, m_ar;
  longint g_cell = 0;
  bit   cap0[256];
  bit   capb[8];
  int   capb_n = 0;

  function automatic bit ref_bit(int slot, bit right);
    logic [15:0] s;
    int ones;
    s = !m_live ? 16'h0 : (right ? m_ar : m_al);
    if (slot >= 12 && slot <= 27) return s[slot-12];
    if (slot == 28) return m_mute;
    if (slot == 31) begin
      ones = m_mute;
      for (int i = 0; i < 16; i++) ones += s[i];
      return ones % 2;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    bit acc, right, b;
    logic [7:0] pat;
    m_new = 0;
    if (!rst_n) begin
      m_cnt = 0; m_frame = 0; m_level = 0; m_pend = 0; m_live = 0; m_mute = 0;
    end else begin
      acc = smp_valid && !m_pend;
      if (cell_en) begin
        m_pos = m_cnt % 64;
        right = (m_cnt >= 64);
        if (m_cnt == 0) begin
          m_live = m_pend;
          m_al = m_pend ? m_pl : 16'h0;
          m_ar = m_pend ? m_pr : 16'h0;
          m_pend = 0;
        end
        if (m_pos == 0) m_mute = mute;
        if (m_pos < 8) begin
          pat = right ? 8'hE4 : (m_frame == 0 ? 8'hE8 : 8'hE2);
          m_level = pat[7-m_pos];
        end else begin
          b = ref_bit(m_pos / 2, right);
          m_level = (m_pos % 2 == 0) ? !m_level : (b ? !m_level : m_level);
        end
        m_cnt = (m_cnt + 1) % 128;
        if (m_cnt == 0) m_frame = (m_frame + 1) % 192;
        m_new = 1;
      end
      if (acc) begin
        m_pend = 1; m_pl = smp_left; m_pr = smp_right;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    string tag;
    cyc++;
    if (rst_n && !done) begin
      if (!m_new)                          tag = "R1";
      else if (m_pos < 8)                  tag = "R2";
      else if (m_pos == 56 || m_pos == 57) tag = "R8";
      else if (m_pos >= 62)                tag = "R7";
      else if (m_pos % 2 == 0)             tag = "R5";
      else                                 tag = "R4";
      check(line_out === m_level, tag, line_out, m_level);
      check(smp_ready === !m_pend, "R9", smp_ready, !m_pend);
      if (m_new) begin
        if (g_cell < 256) cap0[g_cell] = line_out;
        if (g_cell >= 192*128 && g_cell < 192*128 + 8) begin
          capb[g_cell - 192*128] = line_out;
          capb_n++;
        end
        g_cell++;
      end
    end
    if (cyc > 190000 && !done) begin
      done = 1;
      check(0, "watchdog", cyc, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) cell_en <= (cyc % 7 != 3);

  task automatic send(input logic [15:0] l, input logic [15:0] r);
    @(negedge clk);
    smp_left = l; smp_right = r; smp_valid = 1;
    while (!smp_ready) @(negedge clk);
    @(negedge clk);
    smp_valid = 0;
  endtask

  function automatic bit pat_ok(int base, logic [7:0] pat, bit blk);
    for (int k = 0; k < 8; k++) begin
      if ((blk ? capb[k] : cap0[base+k]) != pat[7-k]) return 0;
    end
    return 1;
  endfunction

  initial begin
    bit silence_ok;
    logic [15:0] l, r;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(line_out === 1'b0, "R10 line", line_out, 0);
    check(smp_ready === 1'b1, "R10 ready", smp_ready, 1);
    @(negedge clk);
    rst_n = 1;
    while (g_cell < 260) @(negedge clk);
    for (int i = 0; i < 200; i++) begin
      if (i == 30) mute = 1;
      if (i == 50) mute = 0;
      if (i % 37 == 20) repeat (400) @(negedge clk); // underrun gap (R6)
      if (i == 0)      begin l = 16'hFFFF; r = 16'h0000; end
      else if (i == 1) begin l = 16'h8000; r = 16'h0001; end
      else begin l = 16'(i * 16'h0519) ^ 16'hA5C3; r = ~16'(i * 16'h3301); end
      send(l, r);
    end
    repeat (400) @(negedge clk);
    done = 1;
    // R2/R3: first frame after reset starts a block; right and later left patterns
    check(pat_ok(0, 8'hE8, 0), "R3 first block sync", cap0[1], 1);
    check(pat_ok(64, 8'hE4, 0), "R2 right sync", cap0[69], 1);
    check(pat_ok(128, 8'hE2, 0), "R2 left sync", cap0[134], 1);
    // R6: silence subframe data cells are 1100 repeated
    silence_ok = 1;
    for (int k = 8; k < 64; k++) if (cap0[k] != (((k - 8) % 4) < 2)) silence_ok = 0;
    check(silence_ok, "R6 silence cells", silence_ok, 1);
    check(capb_n == 8, "R3 frame 192 captured", capb_n, 8);
    check(pat_ok(0, 8'hE8, 1), "R3 block sync after 192 frames", capb[4], 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule